// File: doc/BRIEF.md
# Shared Hardware Semaphore Bank

This peripheral holds a bank of one-bit hardware locks that several processors use for mutual exclusion. Each lock is visible as its own 32-bit word on a simple register bus. Reading a lock word is an atomic test-and-set. The read returns the lock's previous state in bit 0, and if the lock was free the same access marks it taken. Software releases a lock by writing zero to its word. A read-only status word tells software how many locks the bank was built with.

The bank has one bus port per master, up to `NUM_PORTS` of them. All ports are served in every cycle. When accesses arrive on several ports in the same cycle they are applied in a fixed order, lowest port first. Each access sees the lock state that the lower-numbered ports left behind, so two readers racing for one free lock can never both win.

The lock count is fixed when the block is built and must be 32, 64, 128 or 256. Read data is registered, and locks change on the same clock edge that produces the read data. Reset is synchronous and active high.

Top module: `hw_semaphore_bank`

## Requirements
- R1: After a synchronous reset, every lock is free and every `bus_rdata` word is 0, including locks that were taken before the reset.
- R2: A read of a free lock returns 0x00000000 and leaves the lock taken. The upper 31 bits of any lock read are always 0.
- R3: A read of a taken lock returns 0x00000001 and leaves the lock taken.
- R4: Writing the value 0 to a lock word releases that lock, so the next read returns 0.
- R5: Writing any nonzero value to a lock word leaves the lock's state unchanged.
- R6: A read of byte offset 0x014 returns `NUM_LOCKS/32` in bits [31:24] and 0 in all other bits. The field is one-hot: 1, 2, 4 or 8.
- R7: Lock i sits at byte offset 0x800 + 4*i, for i < `NUM_LOCKS`. A read of any other offset (misaligned, past the last lock, or unassigned) returns 0. A write to any such offset changes no lock.
- R8: A write to offset 0x014 has no effect; the status word reads back unchanged.
- R9: Read data appears on `bus_rdata` in the cycle after the read strobe. In a cycle that follows no read on that port, `bus_rdata` is 0.
- R10: Same-cycle accesses from several ports are applied in order, port 0 first. Each port sees the state left by the lower ports, so of several same-cycle reads of one free lock, only the lowest port gets 0.
- R11: If read and write strobes are both high on one port in the same cycle, the read is performed and the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | NUM_PORTS | Read strobe, one bit per port |
| bus_wr | input | NUM_PORTS | Write strobe, one bit per port |
| bus_addr | input | NUM_PORTS*ADDR_W | Byte address per port; port p uses bits [p*ADDR_W +: ADDR_W] |
| bus_wdata | input | NUM_PORTS*DATA_W | Write data per port; port p uses bits [p*DATA_W +: DATA_W] |
| bus_rdata | output | NUM_PORTS*DATA_W | Registered read data per port, valid the cycle after the strobe |

## Verification
The hardest situation to reach is two or more ports hitting the same lock in the same cycle, with every mix of take and release. The case that matters most is a release on one port while another port reads the same lock, in both port orders.

The bench drives directed cycles that place a read/read, release/read and read/release pair on one lock index. It then runs a long random phase whose addresses are confined to a handful of lock indices, so same-cycle collisions happen on most cycles. A behavioural model applies the ports in order and predicts every read word on every clock.

// File: rtl/sem_pkg.sv
package sem_pkg;

  // Address map (byte offsets)
  localparam int STATUS_OFFSET = 'h014;
  localparam int LOCK_BASE     = 'h800;
  localparam int LOCK_STRIDE   = 4;
  localparam int COUNT_LSB     = 24;
  localparam int LOCKS_PER_UNIT = 32;
  localparam int MAX_IDX_W     = 8;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,   // nothing that touches state or returns data
    ACC_TAKE = 2'd1,   // test-and-set read of a lock word
    ACC_FREE = 2'd2,   // release write (data zero) to a lock word
    ACC_STAT = 2'd3    // read of the status word
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e              kind;
    logic [MAX_IDX_W-1:0]   idx;
  } acc_t;

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
  import sem_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_LOCKS = 64
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output acc_t              acc
);
  localparam int IDX_W    = $clog2(NUM_LOCKS);
  localparam int LOCK_END = LOCK_BASE + LOCK_STRIDE * NUM_LOCKS;

  logic              in_lock;
  logic              is_stat;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset  = addr - ADDR_W'(LOCK_BASE);
    in_lock = (addr >= ADDR_W'(LOCK_BASE)) && (addr < ADDR_W'(LOCK_END))
              && (addr[1:0] == 2'b00);
    is_stat = (addr == ADDR_W'(STATUS_OFFSET));
    acc.idx  = MAX_IDX_W'(offset[IDX_W+1:2]);
    acc.kind = ACC_IDLE;
    if (rd) begin
      // a read takes precedence; a simultaneous write is dropped
      if (is_stat)      acc.kind = ACC_STAT;
      else if (in_lock) acc.kind = ACC_TAKE;
    end else if (wr && in_lock && (wdata == '0)) begin
      acc.kind = ACC_FREE;
    end
  end

endmodule

// File: rtl/sem_lock_array.sv
module sem_lock_array
  import sem_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_LOCKS = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  acc_t                 acc      [NUM_PORTS],
  output logic [NUM_PORTS-1:0] old_bit,
  output logic [NUM_LOCKS-1:0] state_q
);
  localparam int IDX_W = $clog2(NUM_LOCKS);

  // view[p] is the lock state as seen by port p after ports 0..p-1 acted
  logic [NUM_LOCKS-1:0] view [NUM_PORTS+1];

  always_comb begin
    view[0] = state_q;
    for (int p = 0; p < NUM_PORTS; p++) begin
      view[p+1]  = view[p];
      old_bit[p] = view[p][acc[p].idx[IDX_W-1:0]];
      case (acc[p].kind)
        ACC_TAKE: view[p+1][acc[p].idx[IDX_W-1:0]] = 1'b1;
        ACC_FREE: view[p+1][acc[p].idx[IDX_W-1:0]] = 1'b0;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= view[NUM_PORTS];
  end

endmodule

// File: rtl/sem_read_port.sv
module sem_read_port
  import sem_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_LOCKS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_t              acc,
  input  logic              old_bit,
  output logic [DATA_W-1:0] rdata
);
  localparam int          UNITS     = NUM_LOCKS / LOCKS_PER_UNIT;
  localparam [DATA_W-1:0] STAT_WORD = DATA_W'(UNITS) << COUNT_LSB;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (acc.kind)
        ACC_TAKE: rdata <= DATA_W'(old_bit);
        ACC_STAT: rdata <= STAT_WORD;
        default:  rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/hw_semaphore_bank.sv
module hw_semaphore_bank
  import sem_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_LOCKS = 64,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS-1:0]        bus_rd,
  input  logic [NUM_PORTS-1:0]        bus_wr,
  input  logic [NUM_PORTS*ADDR_W-1:0] bus_addr,
  input  logic [NUM_PORTS*DATA_W-1:0] bus_wdata,
  output logic [NUM_PORTS*DATA_W-1:0] bus_rdata
);
  localparam bit COUNT_OK = (NUM_LOCKS == 32) || (NUM_LOCKS == 64) ||
                            (NUM_LOCKS == 128) || (NUM_LOCKS == 256);

  generate
    if (!COUNT_OK) begin : g_bad_count
      $error("NUM_LOCKS must be 32, 64, 128 or 256");
    end
  endgenerate

  acc_t                 acc     [NUM_PORTS];
  logic [NUM_PORTS-1:0] old_bit;
  logic [NUM_LOCKS-1:0] lock_state;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    sem_port_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LOCKS(NUM_LOCKS)
    ) u_dec (
      .rd    (bus_rd[p]),
      .wr    (bus_wr[p]),
      .addr  (bus_addr[p*ADDR_W +: ADDR_W]),
      .wdata (bus_wdata[p*DATA_W +: DATA_W]),
      .acc   (acc[p])
    );

    sem_read_port #(
      .DATA_W(DATA_W), .NUM_LOCKS(NUM_LOCKS)
    ) u_rd (
      .clk     (clk),
      .rst     (rst),
      .acc     (acc[p]),
      .old_bit (old_bit[p]),
      .rdata   (bus_rdata[p*DATA_W +: DATA_W])
    );
  end

  sem_lock_array #(
    .NUM_PORTS(NUM_PORTS), .NUM_LOCKS(NUM_LOCKS)
  ) u_locks (
    .clk     (clk),
    .rst     (rst),
    .acc     (acc),
    .old_bit (old_bit),
    .state_q (lock_state)
  );

endmodule

// File: rtl/sem_bank_checker.sv
module sem_bank_checker #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_LOCKS = 64,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_PORTS-1:0]        bus_rd,
  input logic [NUM_PORTS*ADDR_W-1:0] bus_addr,
  input logic [NUM_PORTS*DATA_W-1:0] bus_rdata,
  input logic [NUM_LOCKS-1:0]        lock_state
);
  localparam [DATA_W-1:0] EXP_STAT = DATA_W'(NUM_LOCKS / 32) << 24;
  localparam int          LP       = NUM_PORTS - 1;
  localparam int          IW       = $clog2(NUM_LOCKS);

  function automatic logic is_lock(input logic [ADDR_W-1:0] a);
    return (a[1:0] == 2'b00) && (int'(a) >= 'h800) &&
           (int'(a) < 'h800 + 4 * NUM_LOCKS);
  endfunction

  function automatic logic [IW-1:0] lock_idx(input logic [ADDR_W-1:0] a);
    return IW'((int'(a) - 'h800) / 4);
  endfunction

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    // R9: no read in the previous cycle means a zero read word
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
      !$past(bus_rd[p]) |-> bus_rdata[p*DATA_W +: DATA_W] == '0);

    // R6: status word value
    p_status_word_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(bus_rd[p]) && !$past(rst) &&
       $past(bus_addr[p*ADDR_W +: ADDR_W]) == ADDR_W'('h014))
      |-> bus_rdata[p*DATA_W +: DATA_W] == EXP_STAT);

    // R2: lock read words carry only bit 0
    p_lock_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
      ($past(bus_rd[p]) && is_lock($past(bus_addr[p*ADDR_W +: ADDR_W])))
      |-> bus_rdata[p*DATA_W+1 +: DATA_W-1] == '0);

    for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pair
      // R10: at most one same-cycle reader of a lock may win it
      p_single_winner_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_rd[p]) && $past(bus_rd[q]) && !$past(rst) &&
         is_lock($past(bus_addr[p*ADDR_W +: ADDR_W])) &&
         $past(bus_addr[p*ADDR_W +: ADDR_W]) == $past(bus_addr[q*ADDR_W +: ADDR_W]))
        |-> !(bus_rdata[p*DATA_W] == 1'b0 && bus_rdata[q*DATA_W] == 1'b0));
    end
  end

  // R2: a lock read by the last port is taken afterwards (no later port can undo it)
  p_read_takes_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd[LP]) && !$past(rst) && is_lock($past(bus_addr[LP*ADDR_W +: ADDR_W])))
    |-> lock_state[lock_idx($past(bus_addr[LP*ADDR_W +: ADDR_W]))]);

endmodule

bind hw_semaphore_bank sem_bank_checker #(
  .NUM_PORTS(NUM_PORTS), .NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .lock_state (lock_state)
);

// File: tb/hw_semaphore_bank_test.sv
module hw_semaphore_bank_test;
  localparam int NP = 2;
  localparam int NL = 64;
  localparam int AW = 12;
  localparam int DW = 32;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [NP-1:0]       bus_rd = '0;
  logic [NP-1:0]       bus_wr = '0;
  logic [NP*AW-1:0]    bus_addr = '0;
  logic [NP*DW-1:0]    bus_wdata = '0;
  logic [NP*DW-1:0]    bus_rdata;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  int    model [NL];
  logic [DW-1:0] expd [NP];

  always #5 clk = ~clk;

  hw_semaphore_bank #(.NUM_PORTS(NP), .NUM_LOCKS(NL), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic int lock_of(input int a);
    if (a % 4 == 0 && a >= 'h800 && a < 'h800 + 4 * NL) return (a - 'h800) / 4;
    return -1;
  endfunction

  // behavioural model of one port's access, applied in port order
  function automatic logic [DW-1:0] model_port(input bit rd, input bit wr,
                                               input int a, input int d);
    int li = lock_of(a);
    logic [DW-1:0] r = '0;
    if (rd) begin
      if (a == 'h14) r = DW'(NL / 32) << 24;
      else if (li >= 0) begin
        r = DW'(model[li]);
        model[li] = 1;
      end
    end else if (wr && li >= 0 && d == 0) begin
      model[li] = 0;
    end
    return r;
  endfunction

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // one clock: drive at the falling edge, compare at the next falling edge
  task automatic step(input bit r0, input bit w0, input int a0, input int d0,
                      input bit r1, input bit w1, input int a1, input int d1,
                      input bit do_rst = 1'b0);
    rst = do_rst;
    bus_rd = {r1, r0};
    bus_wr = {w1, w0};
    bus_addr = {AW'(a1), AW'(a0)};
    bus_wdata = {DW'(d1), DW'(d0)};
    if (do_rst) begin
      for (int i = 0; i < NL; i++) model[i] = 0;
      expd[0] = '0; expd[1] = '0;
    end else begin
      expd[0] = model_port(r0, w0, a0, d0);
      expd[1] = model_port(r1, w1, a1, d1);
    end
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      n_checks++;
      if (bus_rdata[p*DW +: DW] !== expd[p]) begin
        n_fail++;
        $display("FAIL %s port %0d: rdata actual %h expected %h", cur_req, p,
                 bus_rdata[p*DW +: DW], expd[p]);
      end
    end
  endtask

  task automatic rd0(input int a);  step(1, 0, a, 0, 0, 0, 0, 0); endtask
  task automatic wr0(input int a, input int d); step(0, 1, a, d, 0, 0, 0, 0); endtask
  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0); endtask

  function automatic int la(input int i); return 'h800 + 4 * i; endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < NL; i++) model[i] = 0;
    @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    step(0, 0, 0, 0, 0, 0, 0, 0, 1'b1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1'b1);
    idle();
    rd0(la(0));
    rd0(la(NL - 1));
    // R9: idle cycles return zero, read data one cycle late
    cur_req = "R9";
    idle();
    idle();
    // R2 / R3: take then observe taken
    cur_req = "R2";
    rd0(la(5));
    cur_req = "R3";
    rd0(la(5));
    rd0(la(5));
    // R4: release
    cur_req = "R4";
    wr0(la(5), 0);
    rd0(la(5));
    // R5: nonzero writes ignored
    cur_req = "R5";
    rd0(la(7));
    wr0(la(7), 1);
    wr0(la(7), 'hFFFF0000);
    rd0(la(7));
    // R6: status word
    cur_req = "R6";
    rd0('h14);
    // R8: status write has no effect
    cur_req = "R8";
    wr0('h14, 0);
    wr0('h14, 'h12345678);
    rd0('h14);
    // R7: unmapped and misaligned offsets
    cur_req = "R7";
    rd0(la(1));
    rd0(la(NL));
    wr0(la(1) + 1, 0);
    wr0(la(NL), 0);
    rd0(la(1));
    rd0('h10);
    rd0(la(2) + 2);
    rd0(la(2));
    // R11: read and write on one port in one cycle
    cur_req = "R11";
    step(1, 1, la(9), 0, 0, 0, 0, 0);
    rd0(la(9));
    // R10: same-cycle collisions
    cur_req = "R10";
    step(1, 0, la(12), 0, 1, 0, la(12), 0);
    step(0, 1, la(12), 0, 1, 0, la(12), 0);
    step(1, 0, la(13), 0, 0, 1, la(13), 0);
    rd0(la(13));
    step(1, 0, la(14), 0, 1, 0, la(15), 0);
    // R1: reset clears held locks
    cur_req = "R1";
    rd0(la(20));
    step(0, 0, 0, 0, 0, 0, 0, 0, 1'b1);
    rd0(la(20));
    rd0(la(12));
    // R10: random collision-heavy traffic
    cur_req = "R10";
    for (int n = 0; n < 4000; n++) begin
      int a [2];
      int d [2];
      bit r [2];
      bit w [2];
      for (int p = 0; p < 2; p++) begin
        int sel = $urandom % 10;
        if (sel < 7)       a[p] = la($urandom % 6);
        else if (sel == 7) a[p] = 'h14;
        else if (sel == 8) a[p] = la(NL) + 4 * ($urandom % 8);
        else               a[p] = $urandom % 4096;
        d[p] = ($urandom % 5 == 0) ? $urandom : 0;
        r[p] = ($urandom % 2) == 1;
        w[p] = ($urandom % 5) < 2;
      end
      step(r[0], w[0], a[0], d[0], r[1], w[1], a[1], d[1]);
    end
    idle();
    finish_up();
  end

endmodule